// File: doc/BRIEF.md
# Image sensor row sequencer

This block drives the row-addressing and pixel-control lines of a CMOS image sensor, one row at a time, from a single master clock. A one-cycle row request starts a fixed sequence of overlapping pulses: a row shift-register clock framed by the pointer sync strobes, then precharge, select, sample-signal, pixel reset and sample-reset. An optional reset-black pulse may follow. When the electronic shutter is enabled, a second reset pulse follows, enclosed by the left/right row-select lines. Each edge-to-edge delay and each pulse width is a 16-bit cycle count, and a count of n gives n+1 master cycles.

A row counter restarts at zero on any row request that carries the frame flag. The shutter pointer sync is sent on row zero. The read pointer sync is sent on the row whose index equals a programmable lead, so the shutter pointer runs that many rows ahead of the read pointer. Both strobes use the same slot within the row. The shutter shift-register clock is a copy of the read row clock.

Top module: `row_seq_top`

## Requirements
- R1: A row request sampled while idle starts a row. busy_o rises in the next cycle and stays high until the sequence ends. done_o then pulses for exactly one cycle, in the first cycle in which busy_o is low.
- R2: Every phase lasts its count plus one cycles, so a count of zero gives a single cycle.
- R3: A sync strobe of the row rises t_sync+1 cycles before the row clock rises. The strobe stays high through the row clock, which is high for t_clk+1 cycles, and for t_sync+1 cycles after the row clock falls. sh_clk_o always equals row_clk_o.
- R4: A request with frame_start_i high is row 0 and latches lead_rows_i. Later requests count up. sync_sh_o fires only on row 0 and only when the shutter is enabled. sync_rd_o fires only on the row whose index equals the latched lead.
- R5: Precharge rises when the sync strobe falls. Select rises t_pc_sel+1 cycles later. Sample-signal rises t_sel_shs+1 cycles after select. Select and sample-signal fall t_shs_unsel+1 cycles after sample-signal rises.
- R6: Pixel reset rises t_unsel_rst+1 cycles after select falls and lasts t_rst+1 cycles. Sample-reset rises as reset falls. Sample-reset and precharge fall together t_shr+1 cycles later.
- R7: With black_en_i set at the request, t_unsel_rst+1 idle cycles and then a further reset pulse of t_rst+1 cycles follow the sample-reset.
- R8: With shutter_en_i set at the request, syl_o and syr_o rise one cycle before a final reset pulse of t_rst+1 cycles and fall one cycle after it ends.
- R9: All counts and both enables are captured at the accepted request. Changes during the row have no effect on that row.
- R10: A request while busy is ignored and leaves the running row unchanged. It sets overrun_o, which stays high until reset.
- R11: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| row_start_i | input | 1 | row request |
| frame_start_i | input | 1 | request is the first row of a frame |
| shutter_en_i | input | 1 | enable shutter reset and shutter sync |
| black_en_i | input | 1 | enable the reset-black pulse |
| lead_rows_i | input | ROW_W | rows by which shutter pointer leads |
| t_sync_i | input | CNT_W | sync set-up / hold count |
| t_clk_i | input | CNT_W | row clock width count |
| t_pc_sel_i | input | CNT_W | precharge to select count |
| t_sel_shs_i | input | CNT_W | select to sample-signal count |
| t_shs_unsel_i | input | CNT_W | sample-signal to select fall count |
| t_unsel_rst_i | input | CNT_W | select fall to reset count |
| t_rst_i | input | CNT_W | reset width count |
| t_shr_i | input | CNT_W | sample-reset width count |
| row_clk_o | output | 1 | read row shift-register clock |
| sh_clk_o | output | 1 | shutter row shift-register clock |
| sync_rd_o | output | 1 | read pointer sync |
| sync_sh_o | output | 1 | shutter pointer sync |
| pc_o | output | 1 | precharge |
| sel_o | output | 1 | row select |
| shs_o | output | 1 | sample signal |
| shr_o | output | 1 | sample reset |
| rst_o | output | 1 | pixel reset |
| syl_o | output | 1 | left row-select |
| syr_o | output | 1 | right row-select |
| busy_o | output | 1 | row sequence running |
| done_o | output | 1 | one-cycle end-of-row pulse |
| overrun_o | output | 1 | sticky request-while-busy flag |

## Verification
The assertions assume that row requests are synchronous to clk_i and that config inputs hold steady in the accept cycle. They also assume no frame runs long enough to saturate the row counter. The directed stimulus changes requests, flags and counts only at falling clock edges. It keeps counts small and frames short. The only requests it sends during a busy row are the ones meant to test rejection.

// File: rtl/row_seq_pkg.sv
package row_seq_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_SYNC_SU, PH_CLK, PH_SYNC_HOLD, PH_PC, PH_SEL, PH_SHS,
    PH_UNSEL, PH_RST, PH_SHR, PH_BLK_GAP, PH_BLK_RST, PH_SH_PRE,
    PH_SH_RST, PH_SH_POST
  } phase_e;

  typedef struct packed {
    logic row_clk;
    logic sync;
    logic pc;
    logic sel;
    logic shs;
    logic shr;
    logic rst;
    logic sy;
  } pins_t;

  function automatic pins_t phase_pins(phase_e ph);
    pins_t p;
    p = '0;
    unique case (ph)
      PH_SYNC_SU, PH_SYNC_HOLD: p.sync = 1'b1;
      PH_CLK:     begin p.sync = 1'b1; p.row_clk = 1'b1; end
      PH_PC, PH_UNSEL: p.pc = 1'b1;
      PH_SEL:     begin p.pc = 1'b1; p.sel = 1'b1; end
      PH_SHS:     begin p.pc = 1'b1; p.sel = 1'b1; p.shs = 1'b1; end
      PH_RST:     begin p.pc = 1'b1; p.rst = 1'b1; end
      PH_SHR:     begin p.pc = 1'b1; p.shr = 1'b1; end
      PH_BLK_RST: p.rst = 1'b1;
      PH_SH_PRE, PH_SH_POST: p.sy = 1'b1;
      PH_SH_RST:  begin p.sy = 1'b1; p.rst = 1'b1; end
      default:    p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/row_seq_timer.sv
module row_seq_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/row_seq_rowctr.sv
module row_seq_rowctr #(
  parameter int unsigned ROW_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             frame_i,
  input  logic             shutter_en_i,
  input  logic [ROW_W-1:0] lead_i,
  output logic             rd_row_o,
  output logic             sh_row_o
);
  localparam logic [ROW_W-1:0] ROW_MAX = {ROW_W{1'b1}};

  logic [ROW_W-1:0] row_q, lead_q, cur_row, cur_lead;
  logic             rd_q, sh_q;

  always_comb begin
    if (frame_i) begin
      cur_row  = '0;
      cur_lead = lead_i;
    end else begin
      cur_row  = (row_q == ROW_MAX) ? row_q : row_q + 1'b1;
      cur_lead = lead_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= ROW_MAX;
      lead_q <= '0;
      rd_q   <= 1'b0;
      sh_q   <= 1'b0;
    end else if (accept_i) begin
      row_q  <= cur_row;
      lead_q <= cur_lead;
      rd_q   <= (cur_row == cur_lead) && (frame_i || row_q != ROW_MAX);
      sh_q   <= shutter_en_i && (cur_row == '0);
    end
  end

  assign rd_row_o = rd_q;
  assign sh_row_o = sh_q;
endmodule

// File: rtl/row_seq_fsm.sv
module row_seq_fsm
  import row_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             expire_i,
  input  logic             black_en_i,
  input  logic             shut_en_i,
  input  logic [CNT_W-1:0] t_sync_live_i,
  input  logic [CNT_W-1:0] t_sync_i,
  input  logic [CNT_W-1:0] t_clk_i,
  input  logic [CNT_W-1:0] t_pc_sel_i,
  input  logic [CNT_W-1:0] t_sel_shs_i,
  input  logic [CNT_W-1:0] t_shs_unsel_i,
  input  logic [CNT_W-1:0] t_unsel_rst_i,
  input  logic [CNT_W-1:0] t_rst_i,
  input  logic [CNT_W-1:0] t_shr_i,
  output phase_e           phase_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             done_o
);
  phase_e phase_q, phase_n, after_shr;
  logic   done_q, step;

  always_comb begin
    after_shr = black_en_i ? PH_BLK_GAP : (shut_en_i ? PH_SH_PRE : PH_IDLE);
    unique case (phase_q)
      PH_SYNC_SU:   phase_n = PH_CLK;
      PH_CLK:       phase_n = PH_SYNC_HOLD;
      PH_SYNC_HOLD: phase_n = PH_PC;
      PH_PC:        phase_n = PH_SEL;
      PH_SEL:       phase_n = PH_SHS;
      PH_SHS:       phase_n = PH_UNSEL;
      PH_UNSEL:     phase_n = PH_RST;
      PH_RST:       phase_n = PH_SHR;
      PH_SHR:       phase_n = after_shr;
      PH_BLK_GAP:   phase_n = PH_BLK_RST;
      PH_BLK_RST:   phase_n = shut_en_i ? PH_SH_PRE : PH_IDLE;
      PH_SH_PRE:    phase_n = PH_SH_RST;
      PH_SH_RST:    phase_n = PH_SH_POST;
      default:      phase_n = PH_IDLE;
    endcase
  end

  function automatic logic [CNT_W-1:0] dur(phase_e ph);
    unique case (ph)
      PH_SYNC_SU, PH_SYNC_HOLD: return t_sync_i;
      PH_CLK:                   return t_clk_i;
      PH_PC:                    return t_pc_sel_i;
      PH_SEL:                   return t_sel_shs_i;
      PH_SHS:                   return t_shs_unsel_i;
      PH_UNSEL, PH_BLK_GAP:     return t_unsel_rst_i;
      PH_RST, PH_BLK_RST, PH_SH_RST: return t_rst_i;
      PH_SHR:                   return t_shr_i;
      default:                  return '0;
    endcase
  endfunction

  assign step       = (phase_q != PH_IDLE) && expire_i;
  assign load_o     = accept_i || step;
  assign load_val_o = accept_i ? t_sync_live_i : dur(phase_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= step && (phase_n == PH_IDLE);
      if (accept_i)  phase_q <= PH_SYNC_SU;
      else if (step) phase_q <= phase_n;
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;
endmodule

// File: rtl/row_seq_top.sv
module row_seq_top
  import row_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned ROW_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             row_start_i,
  input  logic             frame_start_i,
  input  logic             shutter_en_i,
  input  logic             black_en_i,
  input  logic [ROW_W-1:0] lead_rows_i,
  input  logic [CNT_W-1:0] t_sync_i,
  input  logic [CNT_W-1:0] t_clk_i,
  input  logic [CNT_W-1:0] t_pc_sel_i,
  input  logic [CNT_W-1:0] t_sel_shs_i,
  input  logic [CNT_W-1:0] t_shs_unsel_i,
  input  logic [CNT_W-1:0] t_unsel_rst_i,
  input  logic [CNT_W-1:0] t_rst_i,
  input  logic [CNT_W-1:0] t_shr_i,
  output logic             row_clk_o,
  output logic             sh_clk_o,
  output logic             sync_rd_o,
  output logic             sync_sh_o,
  output logic             pc_o,
  output logic             sel_o,
  output logic             shs_o,
  output logic             shr_o,
  output logic             rst_o,
  output logic             syl_o,
  output logic             syr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             overrun_o
);
  localparam int unsigned NCFG = 8;

  phase_e           phase;
  pins_t            pins;
  logic             accept, load, expire, rd_row, sh_row, ovr_q;
  logic             black_q, shut_q;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cfg_live [NCFG];
  logic [CNT_W-1:0] cfg_q    [NCFG];

  assign cfg_live[0] = t_sync_i;
  assign cfg_live[1] = t_clk_i;
  assign cfg_live[2] = t_pc_sel_i;
  assign cfg_live[3] = t_sel_shs_i;
  assign cfg_live[4] = t_shs_unsel_i;
  assign cfg_live[5] = t_unsel_rst_i;
  assign cfg_live[6] = t_rst_i;
  assign cfg_live[7] = t_shr_i;

  assign busy_o = (phase != PH_IDLE);
  assign accept = row_start_i && !busy_o;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cfg_q[g] <= '0;
      else if (accept) cfg_q[g] <= cfg_live[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      black_q <= 1'b0;
      shut_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (accept) begin
        black_q <= black_en_i;
        shut_q  <= shutter_en_i;
      end
      if (row_start_i && busy_o) ovr_q <= 1'b1;
    end
  end

  row_seq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .expire_o(expire)
  );

  row_seq_rowctr #(.ROW_W(ROW_W)) i_rowctr (
    .clk_i, .rst_ni, .accept_i(accept), .frame_i(frame_start_i),
    .shutter_en_i, .lead_i(lead_rows_i), .rd_row_o(rd_row), .sh_row_o(sh_row)
  );

  row_seq_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk_i, .rst_ni, .accept_i(accept), .expire_i(expire),
    .black_en_i(black_q), .shut_en_i(shut_q), .t_sync_live_i(t_sync_i),
    .t_sync_i(cfg_q[0]), .t_clk_i(cfg_q[1]), .t_pc_sel_i(cfg_q[2]),
    .t_sel_shs_i(cfg_q[3]), .t_shs_unsel_i(cfg_q[4]), .t_unsel_rst_i(cfg_q[5]),
    .t_rst_i(cfg_q[6]), .t_shr_i(cfg_q[7]),
    .phase_o(phase), .load_o(load), .load_val_o(load_val), .done_o(done_o)
  );

  assign pins      = phase_pins(phase);
  assign row_clk_o = pins.row_clk;
  assign sh_clk_o  = pins.row_clk;
  assign sync_rd_o = pins.sync && rd_row;
  assign sync_sh_o = pins.sync && sh_row;
  assign pc_o      = pins.pc;
  assign sel_o     = pins.sel;
  assign shs_o     = pins.shs;
  assign shr_o     = pins.shr;
  assign rst_o     = pins.rst;
  assign syl_o     = pins.sy;
  assign syr_o     = pins.sy;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/row_seq_chk.sv
module row_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic row_start_i,
  input logic row_clk_o,
  input logic sync_rd_o,
  input logic sync_sh_o,
  input logic pc_o,
  input logic sel_o,
  input logic shs_o,
  input logic rst_o,
  input logic syl_o,
  input logic busy_o,
  input logic done_o,
  input logic overrun_o
);
  assert_sync_edge_clk_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sync_rd_o) || $fell(sync_rd_o) || $rose(sync_sh_o) || $fell(sync_sh_o)) |-> !row_clk_o);

  assert_sync_held_past_clk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_clk_o && sync_rd_o) |=> sync_rd_o);

  assert_sel_inside_pc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_o) |-> (pc_o && $past(pc_o)));

  assert_shs_after_sel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shs_o) |-> (sel_o && $past(sel_o)));

  assert_rst_after_unsel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> (!sel_o && $past(!sel_o)));

  assert_sy_lead_rst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rst_o) && syl_o) |-> $past(syl_o));

  assert_sy_trail_rst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(syl_o) |-> (!rst_o && $past(!rst_o)));

  assert_done_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_done_one_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_overrun_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && row_start_i) |=> overrun_o);

  assert_overrun_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

bind row_seq_top row_seq_chk i_row_seq_chk (.*);

// File: tb/test_row_seq_top.sv
module test_row_seq_top;
  localparam int CNT_W = 16;
  localparam int ROW_W = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic row_start = 0, frame_start = 0, shutter_en = 0, black_en = 0;
  logic [ROW_W-1:0] lead = '0;
  logic [CNT_W-1:0] ta = 0, tk = 0, td = 0, te = 0, tf = 0, tg = 0, th = 0, tm = 0;
  logic row_clk, sh_clk, sync_rd, sync_sh, pc, sel, shs, shr, rst, syl, syr, busy, done, overrun;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  row_seq_top #(.CNT_W(CNT_W), .ROW_W(ROW_W)) i_row_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .row_start_i(row_start), .frame_start_i(frame_start),
    .shutter_en_i(shutter_en), .black_en_i(black_en), .lead_rows_i(lead),
    .t_sync_i(ta), .t_clk_i(tk), .t_pc_sel_i(td), .t_sel_shs_i(te),
    .t_shs_unsel_i(tf), .t_unsel_rst_i(tg), .t_rst_i(th), .t_shr_i(tm),
    .row_clk_o(row_clk), .sh_clk_o(sh_clk), .sync_rd_o(sync_rd), .sync_sh_o(sync_sh),
    .pc_o(pc), .sel_o(sel), .shs_o(shs), .shr_o(shr), .rst_o(rst), .syl_o(syl),
    .syr_o(syr), .busy_o(busy), .done_o(done), .overrun_o(overrun)
  );

  // expected-row settings (captured at request time)
  int xa, xk, xd, xe, xf, xg, xh, xm;
  bit xrd, xsh, xblk, xshut;

  function automatic logic [12:0] actual();
    return {row_clk, sh_clk, sync_rd, sync_sh, pc, sel, shs, shr, rst, syl, syr, busy, done};
  endfunction

  function automatic bit in_rng(int i, int lo, int hi);
    return (i >= lo) && (i < hi);
  endfunction

  function automatic int row_len();
    int t;
    t = 3 * 0 + (xa + 1) + (xk + 1) + (xa + 1) + (xd + 1) + (xe + 1) + (xf + 1)
        + (xg + 1) + (xh + 1) + (xm + 1);
    if (xblk)  t += (xg + 1) + (xh + 1);
    if (xshut) t += xh + 3;
    return t;
  endfunction

  function automatic logic [12:0] expect_at(int i);
    int s1, s2, s3, s4, s5, s6, s7, s8, s9, t;
    logic clk_e, syn, pc_e, sel_e, shs_e, shr_e, rst_e, sy_e;
    s1 = xa + 1;  s2 = s1 + xk + 1; s3 = s2 + xa + 1; s4 = s3 + xd + 1;
    s5 = s4 + xe + 1; s6 = s5 + xf + 1; s7 = s6 + xg + 1; s8 = s7 + xh + 1;
    s9 = s8 + xm + 1;
    clk_e = in_rng(i, s1, s2);
    syn   = in_rng(i, 0, s3);
    pc_e  = in_rng(i, s3, s9);
    sel_e = in_rng(i, s4, s6);
    shs_e = in_rng(i, s5, s6);
    rst_e = in_rng(i, s7, s8);
    shr_e = in_rng(i, s8, s9);
    sy_e  = 1'b0;
    t = s9;
    if (xblk) begin
      rst_e |= in_rng(i, t + xg + 1, t + xg + xh + 2);
      t += xg + xh + 2;
    end
    if (xshut) begin
      sy_e  = in_rng(i, t, t + xh + 3);
      rst_e |= in_rng(i, t + 1, t + xh + 2);
      t += xh + 3;
    end
    return {clk_e, clk_e, syn && xrd, syn && xsh, pc_e, sel_e, shs_e, shr_e, rst_e,
            sy_e, sy_e, i < t, i == t};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic capture(bit rd_e, bit sh_e);
    xa = ta; xk = tk; xd = td; xe = te; xf = tf; xg = tg; xh = th; xm = tm;
    xrd = rd_e; xsh = sh_e; xblk = black_en; xshut = shutter_en;
  endtask

  // run one row; ovr_at/chg_at >= 0 inject a busy request / config change
  task automatic run_row(string req, bit frame, bit rd_e, bit sh_e, int ovr_at, int chg_at);
    int len;
    capture(rd_e, sh_e);
    len = row_len();
    frame_start = frame;
    row_start   = 1'b1;
    for (int i = 0; i <= len + 1; i++) begin
      @(negedge clk);
      if (i == 0) begin row_start = 1'b0; frame_start = 1'b0; end
      check(req, {19'd0, actual()}, {19'd0, expect_at(i)});
      if (i == ovr_at) row_start = 1'b1;
      if (i == ovr_at + 1) row_start = 1'b0;
      if (i == chg_at) begin
        ta = 9; tk = 9; td = 9; te = 9; tf = 9; tg = 9; th = 9; tm = 9;
        shutter_en = ~shutter_en; black_en = ~black_en;
      end
    end
    if (chg_at >= 0) begin
      ta = xa; tk = xk; td = xd; te = xe; tf = xf; tg = xg; th = xh; tm = xm;
      shutter_en = xshut; black_en = xblk;
    end
  endtask

  task automatic set_cnt(int a, int k, int d, int e, int f, int g, int h, int m);
    ta = a; tk = k; td = d; te = e; tf = f; tg = g; th = h; tm = m;
  endtask

  task automatic test_reset_R11();
    @(negedge clk);
    check("R11", {19'd0, actual()}, 32'd0);
    check("R11", {31'd0, overrun}, 32'd0);
  endtask

  task automatic test_basic_R1_R2_R3();
    set_cnt(1, 2, 1, 2, 1, 2, 1, 2);
    shutter_en = 0; black_en = 0; lead = 0;
    run_row("R1 R3 R5 R6", 1, 1, 0, -1, -1);
    set_cnt(0, 0, 0, 0, 0, 0, 0, 0);  // all zero: one cycle per phase
    run_row("R2", 1, 1, 0, -1, -1);
    set_cnt(3, 5, 2, 0, 4, 1, 3, 0);
    run_row("R2 R5 R6", 0, 0, 0, -1, -1);
  endtask

  task automatic test_frame_R4();
    set_cnt(1, 1, 0, 1, 0, 1, 1, 0);
    shutter_en = 1; black_en = 0; lead = 2;
    run_row("R4 R8", 1, 0, 1, -1, -1);  // row 0: shutter sync only
    lead = 0;                           // not latched mid-frame
    run_row("R4", 0, 0, 0, -1, -1);     // row 1
    run_row("R4", 0, 1, 0, -1, -1);     // row 2: read sync (lead 2)
    run_row("R4", 0, 0, 0, -1, -1);     // row 3: none
    shutter_en = 0;
    run_row("R4", 1, 1, 0, -1, -1);     // new frame, lead 0, no shutter
  endtask

  task automatic test_black_R7();
    set_cnt(0, 1, 1, 0, 1, 2, 2, 1);
    black_en = 1; shutter_en = 0;
    run_row("R7", 0, 0, 0, -1, -1);
    shutter_en = 1;
    run_row("R7 R8", 0, 0, 0, -1, -1);
    black_en = 0; shutter_en = 0;
  endtask

  task automatic test_latch_R9();
    set_cnt(2, 1, 1, 1, 2, 0, 1, 1);
    run_row("R9", 0, 0, 0, -1, 2);
  endtask

  task automatic test_overrun_R10();
    check("R10", {31'd0, overrun}, 32'd0);
    set_cnt(1, 1, 1, 1, 1, 1, 1, 1);
    run_row("R10", 0, 0, 0, 3, -1);
    check("R10", {31'd0, overrun}, 32'd1);
    run_row("R10", 0, 0, 0, -1, -1);
    check("R10", {31'd0, overrun}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset_R11();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset_R11();
    test_basic_R1_R2_R3();
    test_frame_R4();
    test_black_R7();
    test_latch_R9();
    test_overrun_R10();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule